// File: doc/BRIEF.md
# Shutdown Event Controller

This block decides when the power-state machine of a power-management chip leaves its running states for OFF. It watches six shutdown sources and merges them into one decision. The sources are a software chip-on bit, GPIO pins configured for power-off, a long press of the on-key, a watchdog that acts only after repeated faults, fault flags enabled for shutdown, and a thermal trip. Each source has its own qualification rule. The level inputs use polarity-selectable hold timers driven by a 1 ms tick. The watchdog uses a saturating count of earlier time-outs. The remaining sources act as single-cycle strobes.

The block also keeps a small three-state machine (OFF, ACTIVE, HIBERNATE) with wake and hibernate requests. When the state drops to OFF, a 3-bit cause code records which source did it. The code stays visible until the next wake. The rest of the chip reads the state and the cause, and the register bus that writes the config bits sits outside.

Top module: `pwr_shutdown_ctrl`

## Requirements
- R1: After reset the state is OFF (code 0) and the cause code is 0.
- R2: State codes are OFF=0, ACTIVE=1, HIBERNATE=2. From OFF, wakeReq moves to ACTIVE on the next edge and clears the cause to 0. From ACTIVE, hibReq moves to HIBERNATE. From HIBERNATE, wakeReq moves back to ACTIVE.
- R3: In ACTIVE or HIBERNATE, a software chip-on write with data 0 moves to OFF with cause 6. A write with data 1 has no effect.
- R4: A GPIO enabled for power-off is active when its pin level equals its polarity bit. After more than GPIO_HOLD_MS (default 5) ticks of continuous activity, the state goes to OFF with cause 4. After exactly GPIO_HOLD_MS ticks it does not.
- R5: A hold timer restarts from zero whenever its input goes inactive before the threshold is passed.
- R6: The on-key is active when its level equals onKeyPol. Holding it for more than ONKEY_LONG_MS (10000) ticks gives OFF with cause 5. With onKeyShortHold=1 the threshold is ONKEY_SHORT_MS (5000) instead.
- R7: A watchdog time-out causes OFF with cause 3 only when WDOG_PRIOR (7) earlier time-outs have been counted. The count saturates and is cleared on entry to OFF.
- R8: A fault flag whose shutdown-enable bit is set gives OFF with cause 2. A thermal trip gives OFF with cause 1. A flag whose enable bit is clear has no effect.
- R9: When several sources are valid in the same cycle, the lowest non-zero cause code wins. The order is thermal 1, fault 2, watchdog 3, GPIO 4, on-key 5, software 6.
- R10: While the state is OFF, shutdown events are ignored: the state stays OFF and the cause code keeps its value.
- R11: A GPIO whose power-off enable bit is clear never causes shutdown, whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| wakeReq | input | 1 | Start-up / resume request |
| hibReq | input | 1 | Enter-hibernate request |
| swChipOnWr | input | 1 | Write strobe for the chip-on bit |
| swChipOnData | input | 1 | Value written to the chip-on bit |
| gpioPin | input | NGPIO | Raw GPIO levels |
| gpioPol | input | NGPIO | Active level per GPIO |
| gpioPwrOffEn | input | NGPIO | GPIO configured as power-off input |
| onKeyPin | input | 1 | Raw on-key level |
| onKeyPol | input | 1 | Active level of the on-key |
| onKeyShortHold | input | 1 | Selects the short on-key hold time |
| wdogTimeout | input | 1 | Watchdog time-out pulse |
| faultFlags | input | NFAULT | Fault condition flags |
| faultShutEn | input | NFAULT | Per-fault shutdown enable |
| thermalTrip | input | 1 | Thermal shutdown pulse |
| pwrState | output | 2 | Power state code |
| shutCause | output | 3 | Cause of the last shutdown |

## Verification
The hold timers are tried with held levels that stop one tick short of the threshold and one tick past it. Levels of both polarities are used, along with held levels on GPIOs that are not enabled and with holds broken by a single idle cycle. Together these separate an off-by-one threshold, an inverted polarity, a missing enable mask and a timer that does not restart. The watchdog gets runs of seven and eight time-outs before and after an OFF entry, which tells a saturating, cleared counter from one that persists. Random bursts of simultaneous strobes, with random fault masks and software data, probe the priority encoder and the watchdog count against a bench model. Directed events during OFF show that nothing moves the state or the cause there.

// File: rtl/sd_pkg.sv
package sd_pkg;

  typedef enum logic [1:0] {
    PS_OFF       = 2'd0,
    PS_ACTIVE    = 2'd1,
    PS_HIBERNATE = 2'd2
  } pwrState_t;

  localparam logic [2:0] CAUSE_NONE    = 3'd0;
  localparam logic [2:0] CAUSE_THERMAL = 3'd1;
  localparam logic [2:0] CAUSE_FAULT   = 3'd2;
  localparam logic [2:0] CAUSE_WDOG    = 3'd3;
  localparam logic [2:0] CAUSE_GPIO    = 3'd4;
  localparam logic [2:0] CAUSE_ONKEY   = 3'd5;
  localparam logic [2:0] CAUSE_SOFT    = 3'd6;

  // control -> datapath strobes
  typedef struct packed {
    logic armed;    // state is ACTIVE or HIBERNATE
    logic clrWdog;  // entering OFF this cycle
  } sdStrobe_t;

endpackage

// File: rtl/sd_hold_timer.sv
module sd_hold_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] holdCnt;

  // counts ticks of continuous activity, stops one past the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!active) begin
      holdCnt <= '0;
    end else if (tick && (holdCnt <= limit)) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign expired = active && (holdCnt > limit);

endmodule

// File: rtl/sd_datapath.sv
module sd_datapath
  import sd_pkg::*;
#(
  parameter int NGPIO          = 2,
  parameter int NFAULT         = 4,
  parameter int GPIO_HOLD_MS   = 5,
  parameter int ONKEY_LONG_MS  = 10000,
  parameter int ONKEY_SHORT_MS = 5000,
  parameter int WDOG_PRIOR     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              swChipOnWr,
  input  logic              swChipOnData,
  input  logic [NGPIO-1:0]  gpioPin,
  input  logic [NGPIO-1:0]  gpioPol,
  input  logic [NGPIO-1:0]  gpioPwrOffEn,
  input  logic              onKeyPin,
  input  logic              onKeyPol,
  input  logic              onKeyShortHold,
  input  logic              wdogTimeout,
  input  logic [NFAULT-1:0] faultFlags,
  input  logic [NFAULT-1:0] faultShutEn,
  input  logic              thermalTrip,
  input  sdStrobe_t         strobe,
  output logic              sdValid,
  output logic [2:0]        sdCause
);

  localparam int GP_W = $clog2(GPIO_HOLD_MS + 2);
  localparam int OK_W = $clog2(ONKEY_LONG_MS + 2);
  localparam int WD_W = $clog2(WDOG_PRIOR + 1);
  localparam logic [GP_W-1:0] GP_LIMIT   = GP_W'(GPIO_HOLD_MS);
  localparam logic [OK_W-1:0] OK_LONG    = OK_W'(ONKEY_LONG_MS);
  localparam logic [OK_W-1:0] OK_SHORT   = OK_W'(ONKEY_SHORT_MS);
  localparam logic [WD_W-1:0] WD_PRIOR_V = WD_W'(WDOG_PRIOR);

  logic [NGPIO-1:0] gpioExpired;
  logic             onKeyExpired;
  logic [WD_W-1:0]  wdogCnt;

  logic thermHit, faultHit, wdogHit, gpioHit, onKeyHit, softHit;

  // one hold timer per GPIO; idle unless enabled and the machine is armed
  for (genvar g = 0; g < NGPIO; g++) begin : g_gpioTimer
    logic gpioActive;
    assign gpioActive = strobe.armed && gpioPwrOffEn[g] && (gpioPin[g] == gpioPol[g]);
    sd_hold_timer #(.CNT_W(GP_W)) u_gpioTimer (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (msTick),
      .active  (gpioActive),
      .limit   (GP_LIMIT),
      .expired (gpioExpired[g])
    );
  end

  logic onKeyActive;
  logic [OK_W-1:0] onKeyLimit;
  assign onKeyActive = strobe.armed && (onKeyPin == onKeyPol);
  assign onKeyLimit  = onKeyShortHold ? OK_SHORT : OK_LONG;

  sd_hold_timer #(.CNT_W(OK_W)) u_onKeyTimer (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (msTick),
    .active  (onKeyActive),
    .limit   (onKeyLimit),
    .expired (onKeyExpired)
  );

  // watchdog fault history, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogCnt <= '0;
    end else if (strobe.clrWdog) begin
      wdogCnt <= '0;
    end else if (strobe.armed && wdogTimeout && (wdogCnt < WD_PRIOR_V)) begin
      wdogCnt <= wdogCnt + 1'b1;
    end
  end

  assign thermHit = strobe.armed && thermalTrip;
  assign faultHit = strobe.armed && (|(faultFlags & faultShutEn));
  assign wdogHit  = strobe.armed && wdogTimeout && (wdogCnt == WD_PRIOR_V);
  assign gpioHit  = |gpioExpired;
  assign onKeyHit = onKeyExpired;
  assign softHit  = strobe.armed && swChipOnWr && !swChipOnData;

  // fixed priority, lowest code first
  always_comb begin
    sdCause = CAUSE_NONE;
    if (thermHit)      sdCause = CAUSE_THERMAL;
    else if (faultHit) sdCause = CAUSE_FAULT;
    else if (wdogHit)  sdCause = CAUSE_WDOG;
    else if (gpioHit)  sdCause = CAUSE_GPIO;
    else if (onKeyHit) sdCause = CAUSE_ONKEY;
    else if (softHit)  sdCause = CAUSE_SOFT;
  end

  assign sdValid = (sdCause != CAUSE_NONE);

endmodule

// File: rtl/sd_control.sv
module sd_control
  import sd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wakeReq,
  input  logic       hibReq,
  input  logic       sdValid,
  input  logic [2:0] sdCause,
  output sdStrobe_t  strobe,
  output pwrState_t  state,
  output logic [2:0] cause
);

  pwrState_t stateNext;
  logic [2:0] causeNext;

  always_comb begin
    stateNext = state;
    causeNext = cause;
    unique case (state)
      PS_OFF: begin
        if (wakeReq) begin
          stateNext = PS_ACTIVE;
          causeNext = CAUSE_NONE;
        end
      end
      PS_ACTIVE: begin
        if (sdValid) begin
          stateNext = PS_OFF;
          causeNext = sdCause;
        end else if (hibReq) begin
          stateNext = PS_HIBERNATE;
        end
      end
      PS_HIBERNATE: begin
        if (sdValid) begin
          stateNext = PS_OFF;
          causeNext = sdCause;
        end else if (wakeReq) begin
          stateNext = PS_ACTIVE;
        end
      end
      default: begin
        stateNext = PS_OFF;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_OFF;
      cause <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      cause <= causeNext;
    end
  end

  assign strobe.armed   = (state != PS_OFF);
  assign strobe.clrWdog = (state != PS_OFF) && sdValid;

endmodule

// File: rtl/pwr_shutdown_ctrl.sv
module pwr_shutdown_ctrl
  import sd_pkg::*;
#(
  parameter int NGPIO          = 2,
  parameter int NFAULT         = 4,
  parameter int GPIO_HOLD_MS   = 5,
  parameter int ONKEY_LONG_MS  = 10000,
  parameter int ONKEY_SHORT_MS = 5000,
  parameter int WDOG_PRIOR     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              wakeReq,
  input  logic              hibReq,
  input  logic              swChipOnWr,
  input  logic              swChipOnData,
  input  logic [NGPIO-1:0]  gpioPin,
  input  logic [NGPIO-1:0]  gpioPol,
  input  logic [NGPIO-1:0]  gpioPwrOffEn,
  input  logic              onKeyPin,
  input  logic              onKeyPol,
  input  logic              onKeyShortHold,
  input  logic              wdogTimeout,
  input  logic [NFAULT-1:0] faultFlags,
  input  logic [NFAULT-1:0] faultShutEn,
  input  logic              thermalTrip,
  output logic [1:0]        pwrState,
  output logic [2:0]        shutCause
);

  sdStrobe_t  strobe;
  logic       sdValid;
  logic [2:0] sdCause;
  pwrState_t  state;

  sd_datapath #(
    .NGPIO          (NGPIO),
    .NFAULT         (NFAULT),
    .GPIO_HOLD_MS   (GPIO_HOLD_MS),
    .ONKEY_LONG_MS  (ONKEY_LONG_MS),
    .ONKEY_SHORT_MS (ONKEY_SHORT_MS),
    .WDOG_PRIOR     (WDOG_PRIOR)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .msTick         (msTick),
    .swChipOnWr     (swChipOnWr),
    .swChipOnData   (swChipOnData),
    .gpioPin        (gpioPin),
    .gpioPol        (gpioPol),
    .gpioPwrOffEn   (gpioPwrOffEn),
    .onKeyPin       (onKeyPin),
    .onKeyPol       (onKeyPol),
    .onKeyShortHold (onKeyShortHold),
    .wdogTimeout    (wdogTimeout),
    .faultFlags     (faultFlags),
    .faultShutEn    (faultShutEn),
    .thermalTrip    (thermalTrip),
    .strobe         (strobe),
    .sdValid        (sdValid),
    .sdCause        (sdCause)
  );

  sd_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .wakeReq (wakeReq),
    .hibReq  (hibReq),
    .sdValid (sdValid),
    .sdCause (sdCause),
    .strobe  (strobe),
    .state   (state),
    .cause   (shutCause)
  );

  assign pwrState = state;

endmodule

// File: rtl/sd_checker.sv
module sd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wakeReq,
  input logic       hibReq,
  input logic       swChipOnWr,
  input logic       swChipOnData,
  input logic       thermalTrip,
  input logic [1:0] pwrState,
  input logic [2:0] shutCause
);

  AST_RESET_OFF: assert property (@(posedge clk) !rstN |=> (pwrState == 2'd0 && shutCause == 3'd0)); // R1

  AST_CAUSE_CLEAR_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0) |-> (shutCause == 3'd0)); // R2

  AST_HIB_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && hibReq && !thermalTrip && !(swChipOnWr && !swChipOnData)) |=> (pwrState != 2'd1)); // R2

  AST_SOFT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0 && swChipOnWr && !swChipOnData) |=> (pwrState == 2'd0 && shutCause != 3'd0)); // R3

  AST_THERMAL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd0 && thermalTrip) |=> (pwrState == 2'd0 && shutCause == 3'd1)); // R9

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && !wakeReq) |=> (pwrState == 2'd0 && $stable(shutCause))); // R10

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3); // R2

endmodule

bind pwr_shutdown_ctrl sd_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wakeReq      (wakeReq),
  .hibReq       (hibReq),
  .swChipOnWr   (swChipOnWr),
  .swChipOnData (swChipOnData),
  .thermalTrip  (thermalTrip),
  .pwrState     (pwrState),
  .shutCause    (shutCause)
);

// File: tb/pwr_shutdown_ctrl_tb.sv
module pwr_shutdown_ctrl_tb;

  localparam int NGPIO = 2;
  localparam int NFAULT = 4;
  localparam int GPIO_HOLD = 5;
  localparam int OK_LONG = 10000;
  localparam int OK_SHORT = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, wakeReq = 1'b0, hibReq = 1'b0;
  logic swChipOnWr = 1'b0, swChipOnData = 1'b1;
  logic [NGPIO-1:0] gpioPin = '0, gpioPol = '1, gpioPwrOffEn = '0;
  logic onKeyPin = 1'b0, onKeyPol = 1'b1, onKeyShortHold = 1'b0;
  logic wdogTimeout = 1'b0, thermalTrip = 1'b0;
  logic [NFAULT-1:0] faultFlags = '0, faultShutEn = '0;
  logic [1:0] pwrState;
  logic [2:0] shutCause;

  int nChecks = 0;
  int nFails = 0;
  int wdModel = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pwr_shutdown_ctrl u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .wakeReq(wakeReq), .hibReq(hibReq),
    .swChipOnWr(swChipOnWr), .swChipOnData(swChipOnData),
    .gpioPin(gpioPin), .gpioPol(gpioPol), .gpioPwrOffEn(gpioPwrOffEn),
    .onKeyPin(onKeyPin), .onKeyPol(onKeyPol), .onKeyShortHold(onKeyShortHold),
    .wdogTimeout(wdogTimeout), .faultFlags(faultFlags), .faultShutEn(faultShutEn),
    .thermalTrip(thermalTrip), .pwrState(pwrState), .shutCause(shutCause)
  );

  function automatic int expCause(bit th, bit flt, bit wdFire, bit sw0);
    if (th) return 1;
    if (flt) return 2;
    if (wdFire) return 3;
    if (sw0) return 6;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickN(int n);
    repeat (n) begin
      msTick = 1'b1; cyc();
      msTick = 1'b0; cyc();
    end
  endtask

  task automatic wake();
    wakeReq = 1'b1; cyc(); wakeReq = 1'b0;
    if (pwrState == 2'd1) wdModel = 0;
  endtask

  task automatic pulseWdog(int n);
    repeat (n) begin
      wdogTimeout = 1'b1; cyc(); wdogTimeout = 1'b0; cyc();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", lim, 0);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    chk("R1 state", pwrState, 0);
    chk("R1 cause", shutCause, 0);
    rstN = 1'b1; cyc(2);

    // R2 transitions
    wake(); chk("R2 wake", pwrState, 1);
    hibReq = 1'b1; cyc(); hibReq = 1'b0; chk("R2 hib", pwrState, 2);
    wake(); chk("R2 resume", pwrState, 1);

    // R3 software bit
    swChipOnWr = 1'b1; swChipOnData = 1'b1; cyc(); swChipOnWr = 1'b0;
    chk("R3 write1 state", pwrState, 1);
    swChipOnWr = 1'b1; swChipOnData = 1'b0; cyc(); swChipOnWr = 1'b0; swChipOnData = 1'b1;
    chk("R3 write0 state", pwrState, 0);
    chk("R3 write0 cause", shutCause, 6);

    // R10 events in OFF ignored
    thermalTrip = 1'b1; wdogTimeout = 1'b1; swChipOnWr = 1'b1; swChipOnData = 1'b0;
    faultFlags = 4'hF; faultShutEn = 4'hF; cyc();
    thermalTrip = 1'b0; wdogTimeout = 1'b0; swChipOnWr = 1'b0; swChipOnData = 1'b1;
    faultFlags = '0; faultShutEn = '0; cyc();
    chk("R10 state", pwrState, 0);
    chk("R10 cause", shutCause, 6);
    wake(); chk("R2 cause cleared", shutCause, 0);

    // R4 GPIO threshold, active high
    gpioPwrOffEn = 2'b01; gpioPol = 2'b11; gpioPin = 2'b01;
    tickN(GPIO_HOLD); cyc(2);
    chk("R4 at limit", pwrState, 1);
    tickN(1); cyc(2);
    chk("R4 past limit state", pwrState, 0);
    chk("R4 past limit cause", shutCause, 4);
    gpioPin = '0; cyc(); wake();

    // R5 restart on release
    gpioPin = 2'b01; tickN(GPIO_HOLD - 1);
    gpioPin = 2'b00; cyc();
    gpioPin = 2'b01; tickN(GPIO_HOLD - 1); cyc(2);
    chk("R5 restarted", pwrState, 1);
    tickN(2); cyc(2);
    chk("R5 expires after restart", pwrState, 0);
    gpioPin = '0; cyc(); wake();

    // R11 disabled GPIO ignored
    gpioPin = 2'b10; tickN(GPIO_HOLD + 5); cyc(2);
    chk("R11 disabled pin", pwrState, 1);
    // R4 polarity low
    gpioPol = 2'b10; gpioPin = 2'b11; tickN(GPIO_HOLD + 5); cyc(2);
    chk("R4 inactive level", pwrState, 1);
    gpioPin = 2'b10; tickN(GPIO_HOLD + 1); cyc(2);
    chk("R4 low polarity", shutCause, 4);
    gpioPin = 2'b11; gpioPwrOffEn = '0; cyc(); wake();

    // R6 on-key long hold, active high
    onKeyPol = 1'b1; onKeyPin = 1'b1; tickN(OK_LONG); cyc(2);
    chk("R6 long at limit", pwrState, 1);
    tickN(1); cyc(2);
    chk("R6 long cause", shutCause, 5);
    onKeyPin = 1'b0; cyc(); wake();
    // R6 short hold, active low
    onKeyPol = 1'b0; onKeyPin = 1'b1; onKeyShortHold = 1'b1; cyc();
    onKeyPin = 1'b0; tickN(OK_SHORT); cyc(2);
    chk("R6 short at limit", pwrState, 1);
    tickN(1); cyc(2);
    chk("R6 short state", pwrState, 0);
    chk("R6 short cause", shutCause, 5);
    onKeyPin = 1'b1; cyc(); wake();

    // R7 watchdog in hibernate
    hibReq = 1'b1; cyc(); hibReq = 1'b0;
    pulseWdog(7);
    chk("R7 seven faults", pwrState, 2);
    pulseWdog(1);
    chk("R7 eighth state", pwrState, 0);
    chk("R7 eighth cause", shutCause, 3);
    wake(); pulseWdog(7);
    chk("R7 cleared on OFF", pwrState, 1);
    pulseWdog(1);
    chk("R7 again cause", shutCause, 3);
    wake();

    // R8 faults and thermal
    faultFlags = 4'b0001; faultShutEn = 4'b0010; cyc();
    chk("R8 masked fault", pwrState, 1);
    faultShutEn = 4'b0011; cyc(); faultFlags = '0; faultShutEn = '0;
    chk("R8 fault cause", shutCause, 2);
    wake();
    thermalTrip = 1'b1; cyc(); thermalTrip = 1'b0;
    chk("R8 thermal cause", shutCause, 1);
    wake();

    // R9 directed priority
    thermalTrip = 1'b1; swChipOnWr = 1'b1; swChipOnData = 1'b0;
    faultFlags = 4'h1; faultShutEn = 4'h1; cyc();
    thermalTrip = 1'b0; swChipOnWr = 1'b0; swChipOnData = 1'b1; faultFlags = '0; faultShutEn = '0;
    chk("R9 thermal over all", shutCause, 1);
    wake();
    swChipOnWr = 1'b1; swChipOnData = 1'b0; faultFlags = 4'h4; faultShutEn = 4'hC; cyc();
    swChipOnWr = 1'b0; swChipOnData = 1'b1; faultFlags = '0; faultShutEn = '0;
    chk("R9 fault over soft", shutCause, 2);
    wdModel = 0;

    // R9 / R7 random bursts against model
    for (int it = 0; it < 300; it++) begin
      bit th, wd, swW, swD, fltHit, inHib;
      int ec;
      logic [NFAULT-1:0] ff, fe;
      if (pwrState == 2'd0) begin wake(); wdModel = 0; end
      inHib = (pwrState == 2'd2);
      if (!inHib && ($urandom % 4 == 0)) begin
        hibReq = 1'b1; cyc(); hibReq = 1'b0; inHib = 1'b1;
      end
      th = ($urandom % 8 == 0);
      wd = ($urandom % 2 == 0);
      swW = ($urandom % 4 == 0);
      swD = ($urandom % 2 == 0);
      ff = NFAULT'($urandom); fe = NFAULT'($urandom);
      if ($urandom % 3 != 0) fe = '0;
      fltHit = |(ff & fe);
      ec = expCause(th, fltHit, wd && (wdModel == 7), swW && !swD);
      thermalTrip = th; wdogTimeout = wd; swChipOnWr = swW; swChipOnData = swD;
      faultFlags = ff; faultShutEn = fe; cyc();
      thermalTrip = 1'b0; wdogTimeout = 1'b0; swChipOnWr = 1'b0; swChipOnData = 1'b1;
      faultFlags = '0; faultShutEn = '0;
      if (ec != 0) begin
        chk("R9 random state", pwrState, 0);
        chk("R9 random cause", shutCause, ec);
        wdModel = 0;
      end else begin
        chk("R7 random no shutdown", pwrState, inHib ? 2 : 1);
        if (wd && wdModel < 7) wdModel++;
      end
    end

    finished = 1'b1;
    summary();
  end

endmodule